// File: doc/BRIEF.md
# Boot Overlay and Flash Region Controller

This block sits beside the program-memory fetch path of a 16-bit controller. It takes every fetch address and decides, in the same cycle, which of five flash erase blocks answers it, or whether the 2 KB boot ROM answers instead. The flash map is not uniform. The two lowest blocks hold 8 KB each and the three upper blocks hold 16 KB each. A boot ROM can be switched in over the top 2 KB of the space.

The boot switch lives in bit 7 of an auxiliary control register, and software may write it. At reset the switch is also decided from three strap pins and a status byte. Each time the switch turns on, a programming-voltage-ready flag stays low for a fixed delay, which is counted in clock cycles. A small command port takes byte-program, block-erase and chip-erase requests. Each request is checked against the ready flag and then turned into per-block enable strobes, or into an error pulse if it is refused.

The flash arrays, the ROM contents and the voltage generator are outside this block. Only their selects and strobes come from it.

Top module: `bootmap_top`

## Requirements
- R1: With the boot switch off, `flashSel` is one-hot on the fetch address. Bit 0 covers 0x0000–0x1FFF, bit 1 covers 0x2000–0x3FFF, bit 2 covers 0x4000–0x7FFF, bit 3 covers 0x8000–0xBFFF and bit 4 covers 0xC000–0xFFFF. `romSel` is 0.
- R2: With the boot switch on, fetches in 0xF800–0xFFFF give `romSel`=1 and `flashSel`=0. Every other address decodes as in R1.
- R3: At the last clock edge with `rstN` low, the boot switch loads 1 if `statusByte` is non-zero, or if `strapProgN`=0, `strapLatch`=1 and `strapExtAccess`=1 all hold together. Otherwise it loads 0. All other readable bits reset to 0, `pwrValid` included.
- R4: A cycle with `auxWrEn`=1 loads `auxWrData[7]` into the boot switch at the next edge. The readback `auxRdData` gives the boot switch in bit 7, `pwrValid` in bit 5, and 0 in every other bit. Written values in bits other than 7 have no effect.
- R5: `pwrValid` rises exactly READY_CYCLES = CLK_MHZ*READY_US clock edges after the edge at which the boot switch turns on. Writing 1 again while the switch is already on does not restart the count.
- R6: A write that clears the boot switch clears `pwrValid` at the same edge. The next turn-on waits the full READY_CYCLES again.
- R7: `cmdOp` is encoded as 00 idle, 01 byte program, 10 block erase and 11 chip erase. An accepted program request pulses the `progStrobe` bit of the block that holds `cmdAddr`, using the block numbering of R1. The pulse appears one cycle after the request and lasts one cycle.
- R8: An accepted block erase pulses only the `eraseStrobe` bit of the block that holds `cmdAddr`. The pulse appears one cycle later and lasts one cycle.
- R9: An accepted chip erase pulses all five `eraseStrobe` bits in the same cycle.
- R10: A non-idle request made while `pwrValid` is 0 gives a one-cycle `cmdError` pulse on the next cycle and drives no strobe.
- R11: A request is judged against the `pwrValid` value that holds in the cycle it is presented. An auxiliary write in that same cycle does not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapProgN | input | 1 | Strap: program-store enable pin level (active low) |
| strapLatch | input | 1 | Strap: address latch pin level |
| strapExtAccess | input | 1 | Strap: external access pin level |
| statusByte | input | 8 | Boot status byte, sampled during reset |
| fetchAddr | input | 16 | Program fetch address |
| flashSel | output | 5 | One-hot flash block select for the fetch |
| romSel | output | 1 | Boot ROM select for the fetch |
| auxWrEn | input | 1 | Auxiliary register write enable |
| auxWrData | input | 8 | Auxiliary register write data |
| auxRdData | output | 8 | Auxiliary register readback |
| pwrValid | output | 1 | Programming voltage ready |
| cmdValid | input | 1 | Command request valid |
| cmdOp | input | 2 | Command code (see R7) |
| cmdAddr | input | 16 | Command target address |
| progStrobe | output | 5 | Per-block byte-program strobe |
| eraseStrobe | output | 5 | Per-block erase strobe |
| cmdError | output | 1 | Refused-command pulse |

## Verification
A command and a software write that clears the boot switch can land in the same cycle. The bench provokes this by presenting a block-erase request together with a clearing write while `pwrValid` is high. It expects the erase strobe to fire with no error, and it expects the readback and `pwrValid` to drop at that same edge. The count toward `pwrValid` can also overlap with a redundant set write. For that case the bench places such a write in the middle of the delay and checks that the flag still rises on the original edge.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

  localparam int ADDR_W     = 16;
  localparam int NUM_BLOCKS = 5;
  localparam int BLK_IDX_W  = $clog2(NUM_BLOCKS);
  localparam int ROM_LOG2   = 11;   // 2 KB overlay window at the top

  typedef enum logic [1:0] {
    OP_IDLE       = 2'b00,
    OP_PROG       = 2'b01,
    OP_BLK_ERASE  = 2'b10,
    OP_CHIP_ERASE = 2'b11
  } cmdOp_e;

  typedef struct packed {
    logic progGo;
    logic blockEraseGo;
    logic chipEraseGo;
    logic reject;
  } ctrlStrobes_t;

  // Two 8 KB blocks below 0x4000, then three 16 KB blocks.
  function automatic logic [BLK_IDX_W-1:0] blockIndex(input logic [ADDR_W-1:0] addr);
    logic [BLK_IDX_W-1:0] idx;
    if (addr[ADDR_W-1:ADDR_W-2] == 2'b00)
      idx = BLK_IDX_W'(addr[ADDR_W-3]);
    else
      idx = BLK_IDX_W'(addr[ADDR_W-1:ADDR_W-2]) + BLK_IDX_W'(1);
    return idx;
  endfunction

endpackage

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
  import bootmap_pkg::*;
#(
  parameter int CLK_MHZ  = 30,
  parameter int READY_US = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         strapProgN,
  input  logic         strapLatch,
  input  logic         strapExtAccess,
  input  logic [7:0]   statusByte,
  input  logic         auxWrEn,
  input  logic [7:0]   auxWrData,
  input  logic         cmdValid,
  input  logic [1:0]   cmdOp,
  output logic         enboot,
  output logic         pwrValid,
  output ctrlStrobes_t strobes
);

  localparam int READY_CYCLES = CLK_MHZ * READY_US;
  localparam int CNT_W        = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_CYCLES - 1);

  logic             bootAtReset;
  logic             clearWrite;
  logic [CNT_W-1:0] rampCnt;
  cmdOp_e           opCode;

  assign bootAtReset = (|statusByte) || (!strapProgN && strapLatch && strapExtAccess);
  assign clearWrite  = auxWrEn && !auxWrData[7];
  assign opCode      = cmdOp_e'(cmdOp);

  // Boot switch: decided from straps while reset is held, then by software.
  always_ff @(posedge clk) begin
    if (!rstN)        enboot <= bootAtReset;
    else if (auxWrEn) enboot <= auxWrData[7];
  end

  // Ready delay after each turn-on.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampCnt  <= '0;
      pwrValid <= 1'b0;
    end else if (clearWrite) begin
      rampCnt  <= '0;
      pwrValid <= 1'b0;
    end else if (enboot && !pwrValid) begin
      if (rampCnt == CNT_LAST) pwrValid <= 1'b1;
      else                     rampCnt  <= rampCnt + CNT_W'(1);
    end
  end

  // Command gating against the current ready flag.
  always_comb begin
    strobes              = '0;
    strobes.reject       = cmdValid && (opCode != OP_IDLE) && !pwrValid;
    strobes.progGo       = cmdValid && (opCode == OP_PROG) && pwrValid;
    strobes.blockEraseGo = cmdValid && (opCode == OP_BLK_ERASE) && pwrValid;
    strobes.chipEraseGo  = cmdValid && (opCode == OP_CHIP_ERASE) && pwrValid;
  end

  p_pwr_needs_boot_r5: assert property (@(posedge clk) disable iff (!rstN)
    pwrValid |-> enboot);

  p_pwr_rise_after_boot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrValid) |-> $past(enboot));

  p_clear_drops_pwr_r6: assert property (@(posedge clk) disable iff (!rstN)
    auxWrEn && !auxWrData[7] |=> !pwrValid && !enboot);

endmodule

// File: rtl/bootmap_datapath.sv
module bootmap_datapath
  import bootmap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     fetchAddr,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic                  enboot,
  input  logic                  pwrValid,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_BLOCKS-1:0] flashSel,
  output logic                  romSel,
  output logic [NUM_BLOCKS-1:0] progStrobe,
  output logic [NUM_BLOCKS-1:0] eraseStrobe,
  output logic                  cmdError,
  output logic [7:0]            auxRdData
);

  localparam int BOOT_BIT = 7;
  localparam int PWR_BIT  = 5;

  logic                  inOverlay;
  logic [BLK_IDX_W-1:0]  fetchIdx;
  logic [BLK_IDX_W-1:0]  cmdIdx;
  logic [NUM_BLOCKS-1:0] cmdOneHot;

  assign inOverlay = enboot && (&fetchAddr[ADDR_W-1:ROM_LOG2]);
  assign fetchIdx  = blockIndex(fetchAddr);
  assign cmdIdx    = blockIndex(cmdAddr);
  assign romSel    = inOverlay;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign flashSel[b]  = !inOverlay && (fetchIdx == BLK_IDX_W'(b));
    assign cmdOneHot[b] = (cmdIdx == BLK_IDX_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progStrobe  <= '0;
      eraseStrobe <= '0;
      cmdError    <= 1'b0;
    end else begin
      progStrobe  <= strobes.progGo ? cmdOneHot : '0;
      eraseStrobe <= strobes.chipEraseGo  ? {NUM_BLOCKS{1'b1}} :
                     strobes.blockEraseGo ? cmdOneHot : '0;
      cmdError    <= strobes.reject;
    end
  end

  always_comb begin
    auxRdData           = '0;
    auxRdData[BOOT_BIT] = enboot;
    auxRdData[PWR_BIT]  = pwrValid;
  end

  p_single_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({romSel, flashSel}) == 1);

  p_rom_needs_boot_r2: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> enboot);

  p_refuse_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reject |=> cmdError && (progStrobe == '0) && (eraseStrobe == '0));

  p_erase_shape_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eraseStrobe != '0) |-> ($onehot(eraseStrobe) || (&eraseStrobe)));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({|progStrobe, |eraseStrobe, cmdError}));

endmodule

// File: rtl/bootmap_top.sv
module bootmap_top
  import bootmap_pkg::*;
#(
  parameter int CLK_MHZ  = 30,
  parameter int READY_US = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapProgN,
  input  logic        strapLatch,
  input  logic        strapExtAccess,
  input  logic [7:0]  statusByte,
  input  logic [15:0] fetchAddr,
  output logic [4:0]  flashSel,
  output logic        romSel,
  input  logic        auxWrEn,
  input  logic [7:0]  auxWrData,
  output logic [7:0]  auxRdData,
  output logic        pwrValid,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [15:0] cmdAddr,
  output logic [4:0]  progStrobe,
  output logic [4:0]  eraseStrobe,
  output logic        cmdError
);

  logic         enboot;
  ctrlStrobes_t strobes;

  bootmap_ctrl #(.CLK_MHZ(CLK_MHZ), .READY_US(READY_US)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .strapProgN(strapProgN), .strapLatch(strapLatch), .strapExtAccess(strapExtAccess),
    .statusByte(statusByte),
    .auxWrEn(auxWrEn), .auxWrData(auxWrData),
    .cmdValid(cmdValid), .cmdOp(cmdOp),
    .enboot(enboot), .pwrValid(pwrValid), .strobes(strobes)
  );

  bootmap_datapath dp_i (
    .clk(clk), .rstN(rstN),
    .fetchAddr(fetchAddr), .cmdAddr(cmdAddr),
    .enboot(enboot), .pwrValid(pwrValid), .strobes(strobes),
    .flashSel(flashSel), .romSel(romSel),
    .progStrobe(progStrobe), .eraseStrobe(eraseStrobe),
    .cmdError(cmdError), .auxRdData(auxRdData)
  );

endmodule

// File: tb/bootmap_top_tb_top.sv
module bootmap_top_tb_top;

  localparam int READY = 150;   // 30 MHz * 5 us, default parameters

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapProgN = 1'b1, strapLatch = 1'b0, strapExtAccess = 1'b0;
  logic [7:0]  statusByte = 8'h00;
  logic [15:0] fetchAddr = 16'h0000;
  logic [4:0]  flashSel, progStrobe, eraseStrobe;
  logic        romSel, pwrValid, cmdError;
  logic        auxWrEn = 1'b0;
  logic [7:0]  auxWrData = 8'h00, auxRdData;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [15:0] cmdAddr = 16'h0000;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bootmap_top dut_i (.*);

  // {address, block index, in top 2 KB}
  localparam logic [19:0] FETCH_VEC [12] = '{
    {16'h0000, 3'd0, 1'b0}, {16'h1FFF, 3'd0, 1'b0},
    {16'h2000, 3'd1, 1'b0}, {16'h3FFF, 3'd1, 1'b0},
    {16'h4000, 3'd2, 1'b0}, {16'h7FFF, 3'd2, 1'b0},
    {16'h8000, 3'd3, 1'b0}, {16'hBFFF, 3'd3, 1'b0},
    {16'hC000, 3'd4, 1'b0}, {16'hF7FF, 3'd4, 1'b0},
    {16'hF800, 3'd4, 1'b1}, {16'hFFFF, 3'd4, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic pn, input logic la, input logic ea,
                            input logic [7:0] st, input logic [7:0] expAux, input string req);
    @(negedge clk);
    rstN = 1'b0; strapProgN = pn; strapLatch = la; strapExtAccess = ea; statusByte = st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // straps change after release: must not matter
    strapProgN = ~pn; strapLatch = ~la; strapExtAccess = ~ea; statusByte = ~st;
    @(negedge clk);
    chk(req, {8'h00, auxRdData}, {8'h00, expAux});
    chk(req, {15'h0, pwrValid}, 16'h0);
  endtask

  task automatic auxWrite(input logic [7:0] d);
    auxWrEn = 1'b1; auxWrData = d;
    @(negedge clk);
    auxWrEn = 1'b0; auxWrData = 8'h00;
  endtask

  task automatic fetchSweep(input logic enb);
    for (int i = 0; i < 12; i++) begin
      logic [4:0] expSel;
      logic       expRom;
      fetchAddr = FETCH_VEC[i][19:4];
      expRom = enb && FETCH_VEC[i][0];
      expSel = expRom ? 5'b0 : 5'(1 << FETCH_VEC[i][3:1]);
      #1;
      chk(enb ? "R2 flashSel" : "R1 flashSel", {11'h0, flashSel}, {11'h0, expSel});
      chk(enb ? "R2 romSel" : "R1 romSel", {15'h0, romSel}, {15'h0, expRom});
      @(negedge clk);
    end
  endtask

  task automatic command(input logic [1:0] op, input logic [15:0] a,
                         input logic [4:0] expP, input logic [4:0] expE,
                         input logic expErr, input string req);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    chk(req, {11'h0, progStrobe}, {11'h0, expP});
    chk(req, {11'h0, eraseStrobe}, {11'h0, expE});
    chk(req, {15'h0, cmdError}, {15'h0, expErr});
    @(negedge clk);
    chk({req, " one cycle"}, {5'h0, progStrobe, eraseStrobe, cmdError}, 16'h0);
  endtask

  initial begin
    // R3: reset with straps off and zero status
    applyReset(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R3 plain reset");
    fetchSweep(1'b0);

    // R10: refused while not ready
    command(2'b01, 16'h2345, 5'b0, 5'b0, 1'b1, "R10 program refused");
    command(2'b11, 16'h0000, 5'b0, 5'b0, 1'b1, "R10 chip erase refused");

    // R4: write all ones, only bit 7 lands
    auxWrite(8'hFF);
    chk("R4 readback", {8'h0, auxRdData}, 16'h0080);
    // R5: count from the write edge, with a redundant set mid-way
    repeat (59) @(negedge clk);
    auxWrite(8'h80);
    repeat (89) @(negedge clk);
    chk("R5 not yet ready", {15'h0, pwrValid}, 16'h0);
    @(negedge clk);
    chk("R5 ready on time", {15'h0, pwrValid}, 16'h1);
    chk("R4 pwr bit 5", {8'h0, auxRdData}, 16'h00A0);

    fetchSweep(1'b1);

    command(2'b01, 16'h2345, 5'b00010, 5'b0, 1'b0, "R7 program block1");
    command(2'b01, 16'hF900, 5'b10000, 5'b0, 1'b0, "R7 program block4");
    command(2'b10, 16'h9000, 5'b0, 5'b01000, 1'b0, "R8 erase block3");
    command(2'b10, 16'h4000, 5'b0, 5'b00100, 1'b0, "R8 erase block2");
    command(2'b11, 16'h1234, 5'b0, 5'b11111, 1'b0, "R9 chip erase");
    command(2'b00, 16'h1234, 5'b0, 5'b0, 1'b0, "R7 idle op");

    // R11 + R6: erase and clearing write in the same cycle
    cmdValid = 1'b1; cmdOp = 2'b10; cmdAddr = 16'h0000;
    auxWrEn = 1'b1; auxWrData = 8'h00;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00; auxWrEn = 1'b0;
    chk("R11 erase accepted", {11'h0, eraseStrobe}, 16'h0001);
    chk("R11 no error", {15'h0, cmdError}, 16'h0);
    chk("R6 pwr cleared", {15'h0, pwrValid}, 16'h0);
    chk("R6 readback cleared", {8'h0, auxRdData}, 16'h0000);

    // R6: full delay again after re-enable
    @(negedge clk);
    auxWrite(8'h80);
    repeat (READY - 1) @(negedge clk);
    chk("R6 restart not ready", {15'h0, pwrValid}, 16'h0);
    @(negedge clk);
    chk("R6 restart ready", {15'h0, pwrValid}, 16'h1);

    // R3: reset variants
    applyReset(1'b1, 1'b0, 1'b0, 8'h04, 8'h80, "R3 status byte");
    applyReset(1'b0, 1'b1, 1'b1, 8'h00, 8'h80, "R3 strap combo");
    applyReset(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R3 partial straps");
    applyReset(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R3 prog strap high");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule